// File: doc/BRIEF.md
# Feed-Forward Convolutional Encoder

This block is a rate 1/k convolutional encoder for forward error correction. Each clock it can take one data bit. The bit is combined with the bits accepted before it, and the block returns k coded bits. A shift register keeps a sliding window of the most recent accepted inputs. Each coded bit is the XOR of the window positions that one generator polynomial selects. The polynomials are fixed at elaboration and written in octal.

The constraint length is a parameter. It counts the current input bit plus the stored past bits, so the register holds one bit fewer than the constraint length. The number of generator codes can be 2 to 7, and it sets the rate. Elaboration stops with an error if the code count is outside that range, if the constraint length is below 2, or if a code has a bit set at or above the constraint length. The taps come from constants, so unused taps need no logic.

A caller drives `vin` high to mark each bit to be encoded. The coded word is then valid, with `vout` high, on the following clock. The `en` input freezes the whole block. A downstream decoder reads `dout` whenever `vout` is high.

Top module: `conv_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, the stored window, `dout` and `vout` all become zero at that edge.
- R2: The window is {current din, stored bits from newest to oldest}. Code bit K-1 selects the current input and code bit 0 selects the bit accepted K-1 valid inputs earlier. Coded bit i is the XOR of the window bits that code i selects. For a single 1 followed by zeros, output i therefore shows the bits of code i from the most significant bit down, one per accepted input.
- R3: When `en` and `vin` are high at a rising edge and `rst` is low, `dout` holds the coded word for that input after the edge, and `vout` is high.
- R4: When `en` is high, `vin` is low and `rst` is low at an edge, the stored window and `dout` keep their values and `vout` goes low.
- R5: When `en` is low and `rst` is low, the stored window, `dout` and `vout` all keep their values, whatever `vin` and `din` are.
- R6: `dout` is NUM_CODES bits wide, and `dout[i]` is produced by the i-th generator code, where code 0 comes first in the parameter array.
- R7: `rst` takes priority over `en` and `vin`. An input presented during reset is not stored, and the first input accepted after reset sees an all-zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; low freezes all state |
| din | input | 1 | Data bit to encode |
| vin | input | 1 | High marks din as a bit to encode |
| dout | output | NUM_CODES | Coded bits, bit i from generator code i |
| vout | output | 1 | High when dout carries a freshly coded word |

## Verification
A single 1 followed by zeros is fed in after reset. The coded stream then spells out each generator code bit by bit, which exposes a reversed tap order, an off-by-one register length and swapped outputs. Mixed streams interleave valid bits with gaps and enable-low cycles. These show whether idle or frozen cycles disturb the stored history, the held outputs or the valid flag. A second instance with rate 1/3 and a short constraint length is driven with the same patterns to check the output-to-code ordering. A reset in the middle of a stream of ones, followed by a zero input, shows whether the history was truly cleared.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

  localparam int unsigned CODE_W    = 32;
  localparam int unsigned MIN_CODES = 2;
  localparam int unsigned MAX_CODES = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // synchronous clear of window and outputs
    logic accept;    // encode din and shift it into the window
  } encStrobe_t;

endpackage

// File: rtl/conv_enc_ctrl.sv
module conv_enc_ctrl
  import conv_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       vin,
  output encStrobe_t strobe,
  output logic       vout
);

  always_comb begin
    strobe.clearAll = rst;
    strobe.accept   = !rst && en && vin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
    end else if (en) begin
      vout <= vin;
    end
  end

endmodule

// File: rtl/conv_enc_datapath.sv
module conv_enc_datapath
  import conv_enc_pkg::*;
#(
  parameter int unsigned CONSTR_LEN = 7,
  parameter int unsigned NUM_CODES  = 2,
  parameter logic [NUM_CODES-1:0][CODE_W-1:0] GEN_CODES = {32'o133, 32'o171}
) (
  input  logic                 clk,
  input  encStrobe_t           strobe,
  input  logic                 din,
  output logic [NUM_CODES-1:0] dout
);

  localparam int unsigned HIST_W = CONSTR_LEN - 1;

  logic [HIST_W-1:0]     histQ;
  logic [HIST_W-1:0]     histNext;
  logic [CONSTR_LEN-1:0] window;
  logic [NUM_CODES-1:0]  codedBits;

  // window MSB is the current bit, LSB the oldest stored bit
  assign window = {din, histQ};

  generate
    if (HIST_W == 1) begin : g_hist1
      assign histNext = din;
    end else begin : g_histN
      assign histNext = {din, histQ[HIST_W-1:1]};
    end
  endgenerate

  generate
    for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_tap
      localparam logic [CONSTR_LEN-1:0] TAP_MASK = GEN_CODES[gi][CONSTR_LEN-1:0];
      assign codedBits[gi] = ^(window & TAP_MASK);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      histQ <= '0;
      dout  <= '0;
    end else if (strobe.accept) begin
      histQ <= histNext;
      dout  <= codedBits;
    end
  end

endmodule

// File: rtl/conv_encoder.sv
module conv_encoder
  import conv_enc_pkg::*;
#(
  parameter int unsigned CONSTR_LEN = 7,
  parameter int unsigned NUM_CODES  = 2,
  parameter logic [NUM_CODES-1:0][CODE_W-1:0] GEN_CODES = {32'o133, 32'o171}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 din,
  input  logic                 vin,
  output logic [NUM_CODES-1:0] dout,
  output logic                 vout
);

  // elaboration-time parameter checks
  generate
    if (NUM_CODES < MIN_CODES || NUM_CODES > MAX_CODES) begin : g_badCount
      $error("conv_encoder: NUM_CODES must lie in 2..7");
    end
    if (CONSTR_LEN < 2 || CONSTR_LEN > CODE_W) begin : g_badLen
      $error("conv_encoder: CONSTR_LEN out of range");
    end
    for (genvar gc = 0; gc < NUM_CODES; gc++) begin : g_codeChk
      if ((GEN_CODES[gc] >> CONSTR_LEN) != 0) begin : g_wide
        $error("conv_encoder: generator code wider than CONSTR_LEN");
      end
    end
  endgenerate

  encStrobe_t strobe;

  conv_enc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .vin    (vin),
    .strobe (strobe),
    .vout   (vout)
  );

  conv_enc_datapath #(
    .CONSTR_LEN (CONSTR_LEN),
    .NUM_CODES  (NUM_CODES),
    .GEN_CODES  (GEN_CODES)
  ) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .din    (din),
    .dout   (dout)
  );

endmodule

// File: rtl/conv_encoder_chk.sv
module conv_encoder_chk #(
  parameter int unsigned NUM_CODES = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 vin,
  input logic [NUM_CODES-1:0] dout,
  input logic                 vout
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!vout && dout == '0));

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (en && vin) |=> vout);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !vin) |=> (!vout && $stable(dout)));

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(vout) && $stable(dout)));

endmodule

bind conv_encoder conv_encoder_chk #(.NUM_CODES(NUM_CODES)) chk_i (
  .clk  (clk),
  .rst  (rst),
  .en   (en),
  .vin  (vin),
  .dout (dout),
  .vout (vout)
);

// File: tb/conv_encoder_tb_top.sv
`timescale 1ns/1ps
module conv_encoder_tb_top;

  localparam logic [6:0] A_CODE0 = 7'o171;
  localparam logic [6:0] A_CODE1 = 7'o133;
  localparam logic [2:0] B_CODE0 = 3'o7;
  localparam logic [2:0] B_CODE1 = 3'o5;
  localparam logic [2:0] B_CODE2 = 3'o3;

  // {en, vin, din}
  localparam int NVEC = 24;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b111, 3'b110, 3'b111, 3'b111, 3'b101, 3'b111, 3'b011, 3'b010,
    3'b111, 3'b100, 3'b110, 3'b111, 3'b001, 3'b111, 3'b111, 3'b110,
    3'b101, 3'b110, 3'b111, 3'b000, 3'b111, 3'b110, 3'b111, 3'b111
  };

  logic clk = 1'b0;
  logic rst, en, din, vin;
  logic [1:0] doutA;
  logic [2:0] doutB;
  logic voutA, voutB;

  int nTests = 0;
  int nFail  = 0;

  // bench model state
  logic [5:0] hA;
  logic [1:0] hB;
  logic [1:0] expA;
  logic [2:0] expB;
  logic expV;

  always #4 clk = ~clk;

  conv_encoder #(
    .CONSTR_LEN (7), .NUM_CODES (2),
    .GEN_CODES  ({32'o133, 32'o171})
  ) dut_i (
    .clk (clk), .rst (rst), .en (en), .din (din), .vin (vin),
    .dout (doutA), .vout (voutA)
  );

  conv_encoder #(
    .CONSTR_LEN (3), .NUM_CODES (3),
    .GEN_CODES  ({32'o3, 32'o5, 32'o7})
  ) dut3_i (
    .clk (clk), .rst (rst), .en (en), .din (din), .vin (vin),
    .dout (doutB), .vout (voutB)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    hA = '0; hB = '0; expA = '0; expB = '0; expV = 1'b0;
  endtask

  task automatic step(input logic e, input logic v, input logic d);
    logic [6:0] wA;
    logic [2:0] wB;
    rst = 1'b0; en = e; vin = v; din = d;
    if (e) begin
      if (v) begin
        wA = {d, hA};
        wB = {d, hB};
        expA = {^(wA & A_CODE1), ^(wA & A_CODE0)};
        expB = {^(wB & B_CODE2), ^(wB & B_CODE1), ^(wB & B_CODE0)};
        hA = {d, hA[5:1]};
        hB = {d, hB[1]};
        expV = 1'b1;
      end else begin
        expV = 1'b0;
      end
    end
    @(posedge clk); #2;
  endtask

  task automatic doReset();
    rst = 1'b1; en = 1'b1; vin = 1'b1; din = 1'b1;
    modelReset();
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; din = 1'b0; vin = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    doReset();
    // R1 reset state
    check("R1 dout A", {2'b0, doutA}, 4'h0);
    check("R1 dout B", {1'b0, doutB}, 4'h0);
    check("R1 vout", {2'b0, voutB, voutA}, 4'h0);

    // R2 impulse response spells the codes MSB first
    step(1'b1, 1'b1, 1'b1);
    for (int j = 0; j < 7; j++) begin
      check("R2 impulse out0", {3'b0, doutA[0]}, {3'b0, A_CODE0[6-j]});
      check("R2 impulse out1", {3'b0, doutA[1]}, {3'b0, A_CODE1[6-j]});
      if (j < 3) check("R6 impulse rate 1/3", {1'b0, doutB},
                       {1'b0, B_CODE2[2-j], B_CODE1[2-j], B_CODE0[2-j]});
      step(1'b1, 1'b1, 1'b0);
    end

    // table-driven streams
    doReset();
    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][2], VEC[k][1], VEC[k][0]);
      if (!VEC[k][2]) begin
        check("R5 freeze dout", {2'b0, doutA}, {2'b0, expA});
        check("R5 freeze vout", {3'b0, voutA}, {3'b0, expV});
      end else if (!VEC[k][1]) begin
        check("R4 idle dout", {2'b0, doutA}, {2'b0, expA});
        check("R4 idle vout", {3'b0, voutA}, {3'b0, expV});
      end else begin
        check("R2 R3 coded dout", {2'b0, doutA}, {2'b0, expA});
        check("R3 vout", {3'b0, voutA}, {3'b0, expV});
      end
      check("R6 rate 1/3 dout", {1'b0, doutB}, {1'b0, expB});
      check("R6 rate 1/3 vout", {3'b0, voutB}, {3'b0, expV});
    end

    // R7 reset during a stream of ones wins over en/vin
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1);
    doReset();
    check("R7 reset priority dout", {1'b0, doutB}, 4'h0);
    check("R7 reset priority vout", {3'b0, voutA}, 4'h0);
    step(1'b1, 1'b1, 1'b0);
    check("R7 cleared history A", {2'b0, doutA}, 4'h0);
    check("R7 cleared history B", {1'b0, doutB}, 4'h0);
    check("R7 vout after reset", {3'b0, voutA}, 4'h1);

    // R5 enable low ignores valid input, then resumes from held history
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    check("R5 frozen dout A", {2'b0, doutA}, {2'b0, expA});
    check("R5 frozen vout", {3'b0, voutA}, 4'h1);
    step(1'b1, 1'b1, 1'b0);
    check("R5 resumed dout A", {2'b0, doutA}, {2'b0, expA});
    check("R5 resumed dout B", {1'b0, doutB}, {1'b0, expB});

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule